// File: doc/BRIEF.md
# Byte-Lane Data Memory Port

This block connects the memory stage of a 32-bit pipeline to a word-wide synchronous data RAM. It handles five access kinds: word load, signed byte load, unsigned byte load, word store and byte store. All addresses it receives are byte addresses. The block turns each request into three things for the RAM: a word address, a set of per-lane write strobes and a lane-steered write word. It then picks the addressed lane out of the word the RAM returns and widens it into the load result.

The RAM covers only the lowest 1 MB of the address space. A request above that range never reaches the RAM. The address is not folded back into the backed range. Such a store is dropped and such a load returns zero.

The RAM outputs are registered one cycle after the request is sampled. The RAM returns its read word one cycle after that. The load result is registered in the following cycle.

Top module: `mem_lane_port`

## Requirements
- R1: A request is accepted only when `req_valid` is high and `req_op` is a memory opcode: 100000 signed byte load, 100011 word load, 100100 unsigned byte load, 101000 byte store, 101011 word store. For an accepted request whose address is below 0x00100000, `ram_en` is high one cycle later and `ram_addr` equals byte address bits [19:2].
- R2: A word store drives `ram_we` = 4'b1111 and puts the store data unchanged on `ram_wdata`.
- R3: A byte store copies store-data bits [7:0] onto all four lanes of `ram_wdata`. It sets only strobe bit `ram_we[a]`, where a is address bits [1:0].
- R4: A word load returns the RAM word unchanged. Address bits [1:0] are ignored for word accesses.
- R5: A signed byte load returns lane a of the RAM word, sign-extended to 32 bits. The lanes are little-endian: lane 0 is bits [7:0] and lane 3 is bits [31:24].
- R6: An unsigned byte load returns lane a zero-extended, so result bits [31:8] are zero.
- R7: A store to a byte address of 0x00100000 or above leaves `ram_en` and `ram_we` low. Memory contents are unchanged, including the word the address would hit if it were taken modulo 1 MB.
- R8: A load from a byte address of 0x00100000 or above raises `ld_valid` and returns zero. It does not enable the RAM.
- R9: `ld_valid` and `ld_data` are updated three clock edges after the load request is sampled. `ld_valid` is high for one cycle per load.
- R10: While `rst` is high and right after it falls, `ram_en`, `ram_we`, `ld_valid` and `ld_data` are all zero.
- R11: A request with a non-memory opcode causes no RAM access and no `ld_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 6 | Primary opcode of the instruction |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data from the register file |
| ram_addr | output | 18 | Word address to the RAM |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 4 | Per-lane write strobes, bit i drives bits [8i+7:8i] |
| ram_wdata | output | 32 | Lane-steered write word |
| ram_rdata | input | 32 | RAM read word, valid one cycle after `ram_en` |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extended load result |

## Verification
Load extraction and store steering can be in flight together. This happens when a store to the same word is issued in the cycle right after a load: the store's strobes reach the RAM while the load's read word is still being extracted. The bench provokes this with a back-to-back word load and word store to one address. It judges the outcome in two ways. The load must return the value held before the store. A later load must then return the new value. A second back-to-back pair uses a byte store after a byte load, and checks that only the strobed lane changed.

// File: rtl/mem_lane_pkg.sv
package mem_lane_pkg;

  localparam logic [5:0] OPC_LB  = 6'b100000;
  localparam logic [5:0] OPC_LW  = 6'b100011;
  localparam logic [5:0] OPC_LBU = 6'b100100;
  localparam logic [5:0] OPC_SB  = 6'b101000;
  localparam logic [5:0] OPC_SW  = 6'b101011;

  typedef struct packed {
    logic rd;       // load
    logic wr;       // store
    logic narrow;   // byte-sized
    logic sext;     // sign-extend on load
  } mem_cmd_t;

endpackage

// File: rtl/mem_req_decode.sv
module mem_req_decode
  import mem_lane_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int BACKED_LOG2 = 20
) (
  input  logic [5:0]        op,
  input  logic [ADDR_W-1:0] addr,
  output mem_cmd_t          cmd,
  output logic              in_range
);

  always_comb begin
    cmd = '0;
    unique case (op)
      OPC_LW:  cmd = '{rd: 1'b1, wr: 1'b0, narrow: 1'b0, sext: 1'b0};
      OPC_LB:  cmd = '{rd: 1'b1, wr: 1'b0, narrow: 1'b1, sext: 1'b1};
      OPC_LBU: cmd = '{rd: 1'b1, wr: 1'b0, narrow: 1'b1, sext: 1'b0};
      OPC_SW:  cmd = '{rd: 1'b0, wr: 1'b1, narrow: 1'b0, sext: 1'b0};
      OPC_SB:  cmd = '{rd: 1'b0, wr: 1'b1, narrow: 1'b1, sext: 1'b0};
      default: cmd = '0;
    endcase
  end

  generate
    if (BACKED_LOG2 < ADDR_W) begin : g_limit
      assign in_range = (addr[ADDR_W-1:BACKED_LOG2] == '0);
    end else begin : g_full
      assign in_range = 1'b1;
    end
  endgenerate

endmodule

// File: rtl/mem_store_steer.sv
module mem_store_steer
  import mem_lane_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  mem_cmd_t          cmd,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] data,
  output logic [LANES-1:0]  we,
  output logic [DATA_W-1:0] wdata
);

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign wdata[8*i +: 8] = cmd.narrow ? data[7:0] : data[8*i +: 8];
      assign we[i] = cmd.wr & (~cmd.narrow | (off == OFF_W'(i)));
    end
  endgenerate

endmodule

// File: rtl/mem_load_extract.sv
module mem_load_extract #(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic              narrow,
  input  logic              sext,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] result
);

  logic [7:0] lanes [LANES];
  logic [7:0] picked;

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_split
      assign lanes[i] = rdata[8*i +: 8];
    end
  endgenerate

  assign picked = lanes[off];
  assign result = narrow ? {{(DATA_W-8){sext & picked[7]}}, picked} : rdata;

endmodule

// File: rtl/mem_lane_port.sv
module mem_lane_port
  import mem_lane_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int BACKED_LOG2 = 20,
  localparam int LANES      = DATA_W / 8,
  localparam int OFF_W      = $clog2(LANES),
  localparam int WAW        = BACKED_LOG2 - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [5:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [WAW-1:0]    ram_addr,
  output logic              ram_en,
  output logic [LANES-1:0]  ram_we,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              ld_valid,
  output logic [DATA_W-1:0] ld_data
);

  mem_cmd_t          cmd;
  logic              in_range;
  logic              access;
  logic [LANES-1:0]  we_c;
  logic [DATA_W-1:0] wdata_c;
  logic [DATA_W-1:0] ext_c;

  // load bookkeeping, aligned with the RAM read latency
  logic             s1_ld, s1_hit, s1_narrow, s1_sext;
  logic [OFF_W-1:0] s1_off;
  logic             s2_ld, s2_hit, s2_narrow, s2_sext;
  logic [OFF_W-1:0] s2_off;

  mem_req_decode #(.ADDR_W(ADDR_W), .BACKED_LOG2(BACKED_LOG2)) u_dec (
    .op(req_op), .addr(req_addr), .cmd(cmd), .in_range(in_range)
  );

  mem_store_steer #(.DATA_W(DATA_W)) u_steer (
    .cmd(cmd), .off(req_addr[OFF_W-1:0]), .data(req_wdata),
    .we(we_c), .wdata(wdata_c)
  );

  assign access = req_valid & (cmd.rd | cmd.wr) & in_range;

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_en    <= 1'b0;
      ram_we    <= '0;
      ram_addr  <= '0;
      ram_wdata <= '0;
      s1_ld     <= 1'b0;
      s1_hit    <= 1'b0;
      s1_narrow <= 1'b0;
      s1_sext   <= 1'b0;
      s1_off    <= '0;
    end else begin
      ram_en    <= access;
      ram_we    <= access ? we_c : '0;
      ram_addr  <= req_addr[BACKED_LOG2-1:OFF_W];
      ram_wdata <= wdata_c;
      s1_ld     <= req_valid & cmd.rd;
      s1_hit    <= in_range;
      s1_narrow <= cmd.narrow;
      s1_sext   <= cmd.sext;
      s1_off    <= req_addr[OFF_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_ld     <= 1'b0;
      s2_hit    <= 1'b0;
      s2_narrow <= 1'b0;
      s2_sext   <= 1'b0;
      s2_off    <= '0;
    end else begin
      s2_ld     <= s1_ld;
      s2_hit    <= s1_hit;
      s2_narrow <= s1_narrow;
      s2_sext   <= s1_sext;
      s2_off    <= s1_off;
    end
  end

  mem_load_extract #(.DATA_W(DATA_W)) u_ext (
    .narrow(s2_narrow), .sext(s2_sext), .off(s2_off),
    .rdata(ram_rdata), .result(ext_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_valid <= 1'b0;
      ld_data  <= '0;
    end else begin
      ld_valid <= s2_ld;
      ld_data  <= (s2_ld && s2_hit) ? ext_c : '0;
    end
  end

  // R3
  we_shape_chk: assert property (@(posedge clk) disable iff (rst)
    (ram_we != '0) |-> (ram_en && ((ram_we == '1) || $onehot(ram_we))));

  // R3
  narrow_replicate_chk: assert property (@(posedge clk) disable iff (rst)
    (ram_en && $onehot(ram_we)) |-> (ram_wdata == {LANES{ram_wdata[7:0]}}));

  // R7
  backed_only_chk: assert property (@(posedge clk) disable iff (rst)
    ram_en |-> ($past(req_addr[ADDR_W-1:BACKED_LOG2]) == '0));

  // R6
  zero_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (s2_ld && s2_narrow && !s2_sext) |=> (ld_data[DATA_W-1:8] == '0));

  // R8
  unbacked_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (s2_ld && !s2_hit) |=> (ld_data == '0));

  // R9
  ld_latency_chk: assert property (@(posedge clk) disable iff (rst)
    ld_valid |-> $past(req_valid, 3));

endmodule

// File: tb/tb_mem_lane_port.sv
module tb_mem_lane_port;

  localparam logic [5:0] T_LB  = 6'b100000;
  localparam logic [5:0] T_LW  = 6'b100011;
  localparam logic [5:0] T_LBU = 6'b100100;
  localparam logic [5:0] T_SB  = 6'b101000;
  localparam logic [5:0] T_SW  = 6'b101011;
  localparam int NV = 26;

  // {op, addr, wdata, exp_en, exp_we, exp_load}
  localparam logic [106:0] VEC [NV] = '{
    {T_SW,  32'h00000020, 32'h11223344, 1'b1, 4'hF, 32'h0},
    {T_LW,  32'h00000020, 32'h0,        1'b1, 4'h0, 32'h11223344},
    {T_LB,  32'h00000020, 32'h0,        1'b1, 4'h0, 32'h00000044},
    {T_LBU, 32'h00000023, 32'h0,        1'b1, 4'h0, 32'h00000011},
    {T_SB,  32'h00000023, 32'hDEADBEAB, 1'b1, 4'h8, 32'h0},
    {T_LW,  32'h00000020, 32'h0,        1'b1, 4'h0, 32'hAB223344},
    {T_LB,  32'h00000023, 32'h0,        1'b1, 4'h0, 32'hFFFFFFAB},
    {T_LBU, 32'h00000023, 32'h0,        1'b1, 4'h0, 32'h000000AB},
    {T_SB,  32'h00000021, 32'h00000080, 1'b1, 4'h2, 32'h0},
    {T_LB,  32'h00000021, 32'h0,        1'b1, 4'h0, 32'hFFFFFF80},
    {T_LW,  32'h00000022, 32'h0,        1'b1, 4'h0, 32'hAB228044},
    {T_SW,  32'h00100020, 32'hCAFEF00D, 1'b0, 4'h0, 32'h0},
    {T_LW,  32'h00000020, 32'h0,        1'b1, 4'h0, 32'hAB228044},
    {T_LW,  32'h00100020, 32'h0,        1'b0, 4'h0, 32'h0},
    {T_SW,  32'h00000FFC, 32'h7F000001, 1'b1, 4'hF, 32'h0},
    {T_LB,  32'h00000FFF, 32'h0,        1'b1, 4'h0, 32'h0000007F},
    {T_LBU, 32'h00000FFC, 32'h0,        1'b1, 4'h0, 32'h00000001},
    {T_SB,  32'h000FFFFF, 32'h0000005A, 1'b1, 4'h8, 32'h0},
    {T_LBU, 32'h000FFFFF, 32'h0,        1'b1, 4'h0, 32'h0000005A},
    {T_SB,  32'h00100000, 32'h000000FF, 1'b0, 4'h0, 32'h0},
    {T_LB,  32'h000FFFFF, 32'h0,        1'b1, 4'h0, 32'h0000005A},
    {T_SB,  32'h80000020, 32'h00000011, 1'b0, 4'h0, 32'h0},
    {T_LW,  32'h00000020, 32'h0,        1'b1, 4'h0, 32'hAB228044},
    {T_SB,  32'h00000022, 32'h00000077, 1'b1, 4'h4, 32'h0},
    {T_LBU, 32'h00000022, 32'h0,        1'b1, 4'h0, 32'h00000077},
    {T_LW,  32'h00000020, 32'h0,        1'b1, 4'h0, 32'hAB778044}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [5:0]  req_op = '0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [17:0] ram_addr;
  logic        ram_en;
  logic [3:0]  ram_we;
  logic [31:0] ram_wdata;
  logic [31:0] ram_rdata;
  logic        ld_valid;
  logic [31:0] ld_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mem_lane_port dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .ram_addr(ram_addr),
    .ram_en(ram_en), .ram_we(ram_we), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata), .ld_valid(ld_valid), .ld_data(ld_data)
  );

  // bench RAM model: synchronous, read-before-write, low address bits only
  logic [31:0] mem [2048];
  logic [31:0] rd_q = '0;
  initial for (int i = 0; i < 2048; i++) mem[i] = '0;
  always @(posedge clk) begin
    if (ram_en) begin
      rd_q <= mem[ram_addr[10:0]];
      for (int b = 0; b < 4; b++)
        if (ram_we[b]) mem[ram_addr[10:0]][8*b +: 8] <= ram_wdata[8*b +: 8];
    end
  end
  assign ram_rdata = rd_q;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [5:0] op, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  function automatic string tag_of(input logic [5:0] op);
    case (op)
      T_SW:    return "R2";
      T_SB:    return "R3";
      T_LW:    return "R4";
      T_LB:    return "R5";
      default: return "R6";
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 ram_en", {31'b0, ram_en}, 32'h0);
    check("R10 ram_we", {28'b0, ram_we}, 32'h0);
    check("R10 ld_valid", {31'b0, ld_valid}, 32'h0);
    check("R10 ld_data", ld_data, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R10 after release", {27'b0, ram_en, ram_we}, 32'h0);

    for (int v = 0; v < NV; v++) begin
      logic [5:0]  op;
      logic [31:0] a, d, ex;
      logic        en;
      logic [3:0]  we;
      logic        is_ld, is_st;
      string       tg;
      {op, a, d, en, we, ex} = VEC[v];
      is_ld = (op == T_LW) || (op == T_LB) || (op == T_LBU);
      is_st = !is_ld;
      tg = tag_of(op);
      drive(op, a, d);
      // RAM side, one edge after sampling
      check(en ? "R1 ram_en" : (is_st ? "R7 ram_en" : "R8 ram_en"), {31'b0, ram_en}, {31'b0, en});
      check(en ? {tg, " ram_we"} : "R7 ram_we", {28'b0, ram_we}, {28'b0, we});
      if (en) begin
        check("R1 ram_addr", {14'b0, ram_addr}, {14'b0, a[19:2]});
        if (op == T_SW) check("R2 ram_wdata", ram_wdata, d);
        if (op == T_SB) check("R3 ram_wdata", ram_wdata, {4{d[7:0]}});
      end
      @(negedge clk);
      check("R9 early ld_valid", {31'b0, ld_valid}, 32'h0);
      @(negedge clk);
      check("R9 ld_valid", {31'b0, ld_valid}, {31'b0, is_ld});
      if (is_ld) check(en ? tg : "R8", ld_data, ex);
      @(negedge clk);
      check("R9 single pulse", {31'b0, ld_valid}, 32'h0);
    end

    // R11: non-memory opcode
    drive(6'b001000, 32'h00000020, 32'h12345678);
    check("R11 ram_en", {31'b0, ram_en}, 32'h0);
    repeat (2) @(negedge clk);
    check("R11 ld_valid", {31'b0, ld_valid}, 32'h0);

    // overlap: word load then word store to the same word on consecutive cycles
    @(negedge clk);
    req_valid = 1'b1; req_op = T_LW; req_addr = 32'h20; req_wdata = '0;
    @(negedge clk);
    req_op = T_SW; req_wdata = 32'h0BADCAFE;
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 overlap store strobes", {28'b0, ram_we}, 32'hF);
    @(negedge clk);
    check("R4 overlap load old value", ld_data, 32'hAB778044);
    check("R9 overlap ld_valid", {31'b0, ld_valid}, 32'h1);
    drive(T_LW, 32'h20, 32'h0);
    repeat (2) @(negedge clk);
    check("R2 overlap store landed", ld_data, 32'h0BADCAFE);

    // overlap: byte load then byte store to the other lane of the same word
    @(negedge clk);
    req_valid = 1'b1; req_op = T_LBU; req_addr = 32'h21; req_wdata = '0;
    @(negedge clk);
    req_op = T_SB; req_addr = 32'h20; req_wdata = 32'h000000EE;
    @(negedge clk);
    req_valid = 1'b0;
    check("R3 overlap byte strobe", {28'b0, ram_we}, 32'h1);
    @(negedge clk);
    check("R6 overlap byte old value", ld_data, 32'h000000CA);
    drive(T_LW, 32'h20, 32'h0);
    repeat (2) @(negedge clk);
    check("R3 overlap lane merge", ld_data, 32'h0BADCAEE);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule